// File: doc/BRIEF.md
# Read-Capture Calibration Traffic Generator

This block produces the memory traffic that a PHY needs while it trains its read-capture timing. On a start pulse it opens one row, writes a fixed data pattern into a small run of columns, and then keeps the device reading that pattern back with no gaps between bursts. While the device returns the pattern, the block holds both read-calibration enables high for a fixed window so that the PHY can adjust its capture delays. The block does not adjust any delay itself. It only sequences the commands, counts the latencies and times the enables.

Every command leaves on a pair of 10-bit command/address buses: one for the rising half of the clock and one for the falling half. A chip-select line goes low during a command cycle. Write data leaves on two 32-bit buses, one for each clock half, with the same byte value repeated in every lane. The timing values, the row and bank, the pattern bytes, the number of write bursts and the length of the calibration window are all parameters. When the window has ended and the data of the last read has drained, a one-cycle done pulse tells the surrounding initialization sequencer that it can move on.

Top module: `rcal_traffic_gen`

## Requirements
- R1: After reset, and again after a reset applied in the middle of a sequence, the outputs are idle: `cs_n`=1, both command buses are 0, both data buses are 0, and `wr_en`, `wr_strobe`, `rd_en`, `rd_cal_en` and `done` are all 0.
- R2: Let the clock edge that samples `start`=1 while the block is idle be the start edge. An activate appears in the cycle after the start edge. In that cycle `cs_n`=0, `ca_rise` = {BANK[2:0], 4'b0000, 3'b010} and `ca_fall` = ROW.
- R3: The first write command appears T_RCD cycles after the activate. NUM_WR writes follow, one every BL/2 cycles. Each write has `ca_rise` = {BANK, 4'b0000, 3'b001}. Write j carries column j*BL on `ca_fall`.
- R4: For each write seen in cycle W, `wr_en` and `wr_strobe` are 1 in cycles W+WL through W+WL+BL/2-1. In those cycles every byte lane of `wr_data_rise` equals PAT_RISE and every byte lane of `wr_data_fall` equals PAT_FALL. In all other cycles the two strobes are 0 and both data buses are 0.
- R5: The first read command appears WL+BL/2+T_WTR cycles after the last write. After it come exactly ceil(CAL_WIN/(BL/2)) reads, one every BL/2 cycles. Each read has `ca_rise` = {BANK, 4'b0000, 3'b101}. Read i carries column (i mod NUM_WR)*BL. No other command is issued.
- R6: `rd_en` and `rd_cal_en` both rise RL cycles after the first read command. They then stay high for exactly CAL_WIN consecutive cycles.
- R7: `done` is high for exactly one cycle. That cycle is RL + ceil(CAL_WIN/(BL/2))*(BL/2) cycles after the first read command, which is the first cycle with no read data left to come.
- R8: A `start` that is high while a sequence is running has no effect. This holds whether `start` is held high after the start edge or pulsed during the read phase: no extra command appears and `done` keeps its timing.
- R9: `cs_n` is low only in the cycles of the commands above. Whenever `cs_n` is high, both command buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a calibration sequence when the block is idle |
| cs_n | output | 1 | Chip select, low in command cycles |
| ca_rise | output | 10 | Command/address, rising half |
| ca_fall | output | 10 | Command/address, falling half |
| wr_data_rise | output | 32 | Write data, rising half |
| wr_data_fall | output | 32 | Write data, falling half |
| wr_en | output | 1 | Write data valid to the PHY |
| wr_strobe | output | 1 | Write strobe to the PHY, high with `wr_en` |
| rd_cal_en | output | 1 | Read-calibration enable to the PHY |
| rd_en | output | 1 | Read enable to the PHY |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The hardest situations to reach are the ones in which the sequencer is busy while something else arrives: a `start` that comes deep in the read phase, a `start` held high over several edges, and a reset that falls in the middle of a write burst while the latency pipes still hold tokens. The stimulus builds each case directly. One run pulses `start` twenty cycles into the reads. Another holds `start` for three cycles. A third run is cut off by reset while write data is on the bus and is then followed by a clean run. The scoreboard expects every command of a run at its exact cycle, so a stray command or a shifted `done` shows up in the cycle where it happens. The last read and the end of the 2048-cycle enable window are checked at their exact cycle in every run.

// File: rtl/rcal_pkg.sv
package rcal_pkg;

    localparam int CA_W   = 10;
    localparam int BANK_W = 3;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_ACT = 3'b010;
    localparam logic [OP_W-1:0] OP_WR  = 3'b001;
    localparam logic [OP_W-1:0] OP_RD  = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_DRAIN
    } rcal_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ACT,
        CMD_WR,
        CMD_RD
    } rcal_cmd_e;

    typedef struct packed {
        logic            cs_n;
        logic [CA_W-1:0] rise;
        logic [CA_W-1:0] fall;
    } rcal_ca_t;

    localparam rcal_ca_t CA_IDLE = '{cs_n: 1'b1, rise: '0, fall: '0};

    // Build one command word: bank and opcode on the rising half,
    // row (activate) or column (write/read) on the falling half.
    function automatic rcal_ca_t rcal_encode(
        input rcal_cmd_e         kind,
        input logic [BANK_W-1:0] bank,
        input logic [CA_W-1:0]   row,
        input logic [CA_W-1:0]   col
    );
        rcal_ca_t w;
        w = CA_IDLE;
        case (kind)
            CMD_ACT: begin
                w.cs_n = 1'b0;
                w.rise = {bank, {(CA_W-BANK_W-OP_W){1'b0}}, OP_ACT};
                w.fall = row;
            end
            CMD_WR: begin
                w.cs_n = 1'b0;
                w.rise = {bank, {(CA_W-BANK_W-OP_W){1'b0}}, OP_WR};
                w.fall = col;
            end
            CMD_RD: begin
                w.cs_n = 1'b0;
                w.rise = {bank, {(CA_W-BANK_W-OP_W){1'b0}}, OP_RD};
                w.fall = col;
            end
            default: w = CA_IDLE;
        endcase
        return w;
    endfunction

    function automatic int rcal_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rcal_lat_pipe.sv
// Fixed-latency token delay: a token that enters is visible at the
// output DEPTH clock edges later.
module rcal_lat_pipe #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/rcal_hold_window.sv
// Retriggerable hold: a trigger makes active high for LEN cycles,
// starting in the cycle after the trigger edge.
module rcal_hold_window #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (trig) begin
            cnt    <= CW'(LEN - 1);
            active <= 1'b1;
        end else if (active && cnt != '0) begin
            cnt    <= cnt - 1'b1;
        end else begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/rcal_seq_fsm.sv
// Command sequencer: activate, NUM_WR spaced writes, then N_RD
// back-to-back reads, then wait for the read data to drain.
module rcal_seq_fsm
    import rcal_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int BEATS  = 4,
    parameter int NUM_WR = 2,
    parameter int N_RD   = 512,
    parameter int TURN   = 8,
    parameter int IW     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd_busy,
    output rcal_cmd_e     issue,
    output logic [IW-1:0] col_idx,
    output logic          first_rd,
    output logic          done
);
    localparam int GAP_MAX = rcal_max3(T_RCD, TURN, BEATS);
    localparam int CW      = $clog2(GAP_MAX + 1);
    localparam int RW      = $clog2(N_RD + 1);

    rcal_state_e   st, st_n;
    logic [CW-1:0] gap, gap_n;
    logic [IW-1:0] wi, wi_n;
    logic [IW-1:0] rc, rc_n;
    logic [RW-1:0] ri, ri_n;
    logic          prev_busy;

    assign done = (st == ST_DRAIN) && prev_busy && !rd_busy;

    always_comb begin
        st_n     = st;
        gap_n    = gap;
        wi_n     = wi;
        rc_n     = rc;
        ri_n     = ri;
        issue    = CMD_NONE;
        col_idx  = '0;
        first_rd = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    issue = CMD_ACT;
                    gap_n = CW'(T_RCD - 1);
                    wi_n  = '0;
                    st_n  = ST_WR;
                end
            end
            ST_WR: begin
                col_idx = wi;
                if (gap == '0) begin
                    issue = CMD_WR;
                    if (wi == IW'(NUM_WR - 1)) begin
                        gap_n = CW'(TURN - 1);
                        ri_n  = '0;
                        rc_n  = '0;
                        st_n  = ST_RD;
                    end else begin
                        wi_n  = wi + 1'b1;
                        gap_n = CW'(BEATS - 1);
                    end
                end else begin
                    gap_n = gap - 1'b1;
                end
            end
            ST_RD: begin
                col_idx  = rc;
                first_rd = (ri == '0);
                if (gap == '0) begin
                    issue = CMD_RD;
                    rc_n  = (rc == IW'(NUM_WR - 1)) ? '0 : rc + 1'b1;
                    if (ri == RW'(N_RD - 1)) begin
                        st_n = ST_DRAIN;
                    end else begin
                        ri_n  = ri + 1'b1;
                        gap_n = CW'(BEATS - 1);
                    end
                end else begin
                    gap_n = gap - 1'b1;
                end
            end
            ST_DRAIN: begin
                if (done) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            gap       <= '0;
            wi        <= '0;
            rc        <= '0;
            ri        <= '0;
            prev_busy <= 1'b0;
        end else begin
            st        <= st_n;
            gap       <= gap_n;
            wi        <= wi_n;
            rc        <= rc_n;
            ri        <= ri_n;
            prev_busy <= rd_busy;
        end
    end
endmodule

// File: rtl/rcal_traffic_gen.sv
module rcal_traffic_gen
    import rcal_pkg::*;
#(
    parameter int              T_RCD    = 3,
    parameter int              WL       = 2,
    parameter int              RL       = 5,
    parameter int              BL       = 8,
    parameter int              T_WTR    = 2,
    parameter int              NUM_WR   = 2,
    parameter int              CAL_WIN  = 2048,
    parameter int              DW       = 32,
    parameter logic [2:0]      BANK     = 3'd0,
    parameter logic [9:0]      ROW      = 10'h000,
    parameter logic [7:0]      PAT_RISE = 8'hA5,
    parameter logic [7:0]      PAT_FALL = 8'h5A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          cs_n,
    output logic [9:0]    ca_rise,
    output logic [9:0]    ca_fall,
    output logic [DW-1:0] wr_data_rise,
    output logic [DW-1:0] wr_data_fall,
    output logic          wr_en,
    output logic          wr_strobe,
    output logic          rd_cal_en,
    output logic          rd_en,
    output logic          done
);
    localparam int BEATS = BL / 2;
    localparam int N_RD  = (CAL_WIN + BEATS - 1) / BEATS;
    localparam int TURN  = WL + BEATS + T_WTR;
    localparam int LANES = DW / 8;
    localparam int IW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
    localparam int BL_SH = $clog2(BL);

    rcal_cmd_e       issue;
    logic [IW-1:0]   col_idx;
    logic            first_rd;
    logic            rd_busy;
    logic            wr_tok;
    logic [1:0]      rd_tok;
    logic            wr_act;
    logic            cal_act;
    logic [CA_W-1:0] col_addr;
    rcal_ca_t        ca_q;

    rcal_seq_fsm #(
        .T_RCD (T_RCD),
        .BEATS (BEATS),
        .NUM_WR(NUM_WR),
        .N_RD  (N_RD),
        .TURN  (TURN),
        .IW    (IW)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_busy (rd_busy),
        .issue   (issue),
        .col_idx (col_idx),
        .first_rd(first_rd),
        .done    (done)
    );

    // Command register: one command word per issue cycle.
    assign col_addr = CA_W'(col_idx) << BL_SH;

    always_ff @(posedge clk) begin
        if (rst) ca_q <= CA_IDLE;
        else     ca_q <= rcal_encode(issue, BANK, ROW, col_addr);
    end

    assign cs_n    = ca_q.cs_n;
    assign ca_rise = ca_q.rise;
    assign ca_fall = ca_q.fall;

    // Write path: write latency, then one burst of BEATS cycles.
    rcal_lat_pipe #(.WIDTH(1), .DEPTH(WL)) u_wr_pipe (
        .clk (clk),
        .rst (rst),
        .din (issue == CMD_WR),
        .dout(wr_tok)
    );

    rcal_hold_window #(.LEN(BEATS)) u_wr_win (
        .clk   (clk),
        .rst   (rst),
        .trig  (wr_tok),
        .active(wr_act)
    );

    // Read path: read latency; bit 1 marks the first read of the run.
    rcal_lat_pipe #(.WIDTH(2), .DEPTH(RL)) u_rd_pipe (
        .clk (clk),
        .rst (rst),
        .din ({(issue == CMD_RD) && first_rd, issue == CMD_RD}),
        .dout(rd_tok)
    );

    rcal_hold_window #(.LEN(BEATS)) u_rd_win (
        .clk   (clk),
        .rst   (rst),
        .trig  (rd_tok[0]),
        .active(rd_busy)
    );

    rcal_hold_window #(.LEN(CAL_WIN)) u_cal_win (
        .clk   (clk),
        .rst   (rst),
        .trig  (rd_tok[1]),
        .active(cal_act)
    );

    assign rd_en     = cal_act;
    assign rd_cal_en = cal_act;
    assign wr_en     = wr_act;
    assign wr_strobe = wr_act;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_data_rise[8*g +: 8] = wr_act ? PAT_RISE : 8'h00;
        assign wr_data_fall[8*g +: 8] = wr_act ? PAT_FALL : 8'h00;
    end
endmodule

// File: rtl/rcal_traffic_gen_chk.sv
module rcal_traffic_gen_chk
    import rcal_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic [9:0]    ca_rise,
    input logic [9:0]    ca_fall,
    input logic [DW-1:0] wr_data_rise,
    input logic [DW-1:0] wr_data_fall,
    input logic          wr_en,
    input logic          rd_en,
    input logic          done
);
    AST_IDLE_CA_ZERO: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (ca_rise == '0 && ca_fall == '0)); // R9

    AST_RD_SPACED: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ca_rise[2:0] == OP_RD) |=> cs_n); // R5

    AST_WR_DATA_GATED: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (wr_data_rise == '0 && wr_data_fall == '0)); // R4

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_en); // R6

    AST_ACT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ca_rise[2:0] == OP_ACT) |-> (!wr_en && !rd_en)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_en && !wr_en && cs_n)); // R7
endmodule

bind rcal_traffic_gen rcal_traffic_gen_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .ca_rise     (ca_rise),
    .ca_fall     (ca_fall),
    .wr_data_rise(wr_data_rise),
    .wr_data_fall(wr_data_fall),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .done        (done)
);

// File: tb/rcal_traffic_gen_test.sv
`timescale 1ns/1ps
module rcal_traffic_gen_test;
    localparam int         T_RCD   = 3;
    localparam int         WL      = 2;
    localparam int         RL      = 5;
    localparam int         BL      = 8;
    localparam int         T_WTR   = 2;
    localparam int         NUM_WR  = 2;
    localparam int         CAL_WIN = 2048;
    localparam int         BEATS   = BL / 2;
    localparam int         N_RD    = (CAL_WIN + BEATS - 1) / BEATS;
    localparam logic [2:0] BANK    = 3'd5;
    localparam logic [9:0] ROW     = 10'h123;
    localparam logic [31:0] PR     = 32'hA5A5A5A5;
    localparam logic [31:0] PF     = 32'h5A5A5A5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cs_n;
    logic [9:0]  ca_rise, ca_fall;
    logic [31:0] wr_data_rise, wr_data_fall;
    logic        wr_en, wr_strobe, rd_cal_en, rd_en, done;

    always #2.5 clk = ~clk;

    rcal_traffic_gen #(
        .T_RCD(T_RCD), .WL(WL), .RL(RL), .BL(BL), .T_WTR(T_WTR),
        .NUM_WR(NUM_WR), .CAL_WIN(CAL_WIN), .DW(32),
        .BANK(BANK), .ROW(ROW), .PAT_RISE(8'hA5), .PAT_FALL(8'h5A)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .cs_n(cs_n),
        .ca_rise(ca_rise), .ca_fall(ca_fall),
        .wr_data_rise(wr_data_rise), .wr_data_fall(wr_data_fall),
        .wr_en(wr_en), .wr_strobe(wr_strobe),
        .rd_cal_en(rd_cal_en), .rd_en(rd_en), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    // Scoreboard of expected commands.
    int          q_cyc[$];
    logic [9:0]  q_r[$];
    logic [9:0]  q_f[$];
    string       q_tag[$];

    int ws_first, ws_last, en_first, en_last, done_cyc;
    bit run_on = 1'b0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    task automatic push_cmd(input int c, input logic [2:0] op,
                            input logic [9:0] f, input string tag);
        q_cyc.push_back(c);
        q_r.push_back({BANK, 4'b0000, op});
        q_f.push_back(f);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares every cycle against the expected windows and queue.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            bit ew, ee, ed;
            ew = run_on && cyc >= ws_first && cyc <= ws_last;
            ee = run_on && cyc >= en_first && cyc <= en_last;
            ed = run_on && cyc == done_cyc;
            chk(wr_en == ew && wr_strobe == ew, "R4", "write strobes",
                {wr_en, wr_strobe}, {ew, ew});
            chk(wr_data_rise == (ew ? PR : 32'h0), "R4", "rise data",
                wr_data_rise, ew ? PR : 32'h0);
            chk(wr_data_fall == (ew ? PF : 32'h0), "R4", "fall data",
                wr_data_fall, ew ? PF : 32'h0);
            chk(rd_en == ee && rd_cal_en == ee, "R6", "read enables",
                {rd_en, rd_cal_en}, {ee, ee});
            chk(done == ed, "R7", "done", done, ed);
            if (!cs_n) begin
                if (q_cyc.size() == 0) begin
                    chk(1'b0, "R8", "unexpected command", ca_rise, 0);
                end else begin
                    int         ec;
                    logic [9:0] er, ef;
                    string      tg;
                    ec = q_cyc.pop_front();
                    er = q_r.pop_front();
                    ef = q_f.pop_front();
                    tg = q_tag.pop_front();
                    chk(cyc == ec, tg, "command cycle", cyc, ec);
                    chk(ca_rise == er, tg, "ca_rise", ca_rise, er);
                    chk(ca_fall == ef, tg, "ca_fall", ca_fall, ef);
                end
            end else begin
                chk(ca_rise == 10'h0 && ca_fall == 10'h0, "R9",
                    "command bus while deselected", {ca_rise, ca_fall}, 0);
            end
        end
    end

    // Driver: starts one sequence and loads the expected commands.
    task automatic run_seq(input int hold, input bit poke);
        int a, wlast, r0;
        @(negedge clk);
        start = 1'b1;
        a = cyc + 1;
        push_cmd(a, 3'b010, ROW, "R2");
        for (int j = 0; j < NUM_WR; j++)
            push_cmd(a + T_RCD + BEATS * j, 3'b001, 10'(j * BL), "R3");
        wlast = a + T_RCD + BEATS * (NUM_WR - 1);
        r0 = wlast + WL + BEATS + T_WTR;
        for (int i = 0; i < N_RD; i++)
            push_cmd(r0 + BEATS * i, 3'b101, 10'((i % NUM_WR) * BL), "R5");
        ws_first = a + T_RCD + WL;
        ws_last  = wlast + WL + BEATS - 1;
        en_first = r0 + RL;
        en_last  = r0 + RL + CAL_WIN - 1;
        done_cyc = r0 + RL + N_RD * BEATS;
        run_on   = 1'b1;
        repeat (hold) @(negedge clk);
        start = 1'b0;
        if (poke) begin
            while (cyc < r0 + 20) @(negedge clk);
            start = 1'b1; // R8: ignored during the read phase
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc < done_cyc + 3) @(negedge clk);
        chk(q_cyc.size() == 0, "R5", "commands left unseen", q_cyc.size(), 0);
        run_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog expired: done actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(cs_n == 1'b1 && ca_rise == 0 && ca_fall == 0, "R1",
            "command bus after reset", {cs_n, ca_rise, ca_fall}, 21'h100000);
        chk(wr_data_rise == 0 && wr_data_fall == 0, "R1",
            "data after reset", wr_data_rise | wr_data_fall, 0);
        chk({wr_en, wr_strobe, rd_en, rd_cal_en, done} == 5'b0, "R1",
            "strobes after reset", {wr_en, wr_strobe, rd_en, rd_cal_en, done}, 0);
        mon_on = 1'b1;
        repeat (5) @(negedge clk);

        // Plain run with a start pulsed in the read phase (R8).
        run_seq(1, 1'b1);
        repeat (7) @(negedge clk);

        // Start held high over three edges (R8).
        run_seq(3, 1'b0);
        repeat (5) @(negedge clk);

        // R1: reset in the middle of a write burst.
        mon_on = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (T_RCD + WL + 1) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q_cyc.delete();
        q_r.delete();
        q_f.delete();
        q_tag.delete();
        run_on = 1'b0;
        mon_on = 1'b1;
        chk(cs_n == 1'b1 && wr_en == 1'b0 && wr_data_rise == 0, "R1",
            "outputs after mid-run reset", {cs_n, wr_en}, 2'b10);
        repeat (20) @(negedge clk);

        // A clean run after the interrupted one.
        run_seq(1, 1'b0);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule